// File: doc/BRIEF.md
# Reservation Station Pool with Operand Wakeup

This block is a small group of reservation stations for one class of floating-point unit. An issue stage hands it an operation with two source operands. Each operand arrives either as a value or as the tag of the station that will produce it. The pool stores the operation in the lowest-numbered free station and reports that station's tag, so the renaming logic can record who will write the destination. Each cycle every waiting station watches a single tagged result bus. When a tag on the bus matches a missing operand, the station takes the value from the bus and marks the operand as present.

A station whose two operands are both present is ready. Among the ready stations, one is sent each cycle to the functional unit over a valid/ready dispatch stream, lowest station index first. The issue side is also valid/ready: `iss_ready` is low exactly when every station is occupied, and `full` shows the same stall condition as a plain status pin. An offered dispatch stays fixed until the unit accepts it, and the unit may hold `dsp_ready` low for any number of cycles. After dispatch a station stays occupied until the result bus carries that station's own tag. Only then can it be reused.

Station tags are `TAG_BASE + index`, so several pools can share one tag space. A tag value of zero always means "operand already valid". With the default parameters there are three stations with tags 1, 2 and 3.

Top module: `rs_pool`

## Requirements
- R1: After reset no station is occupied: `full` is 0, `iss_ready` is 1, `dsp_valid` is 0, and `iss_tag` shows `TAG_BASE`.
- R2: An accepted issue (`iss_valid && iss_ready` at a clock edge) fills the lowest-indexed free station. `iss_tag` shows, before the edge, the tag `TAG_BASE + index` of the station that will be filled.
- R3: When every station is occupied, `full` is 1 and `iss_ready` is 0. An issue presented during that time leaves no trace in the pool.
- R4: An operand whose tag field is 0 takes its value from the issue port. A station issued with both tags 0 offers itself for dispatch in the cycle after the issue edge.
- R5: When `bc_valid` is 1 and `bc_tag` (non-zero) equals a pending operand tag, the station latches `bc_data` as that operand at that edge and clears the tag. The station can be offered in the following cycle if its other operand is present.
- R6: A broadcast in the same cycle as an issue whose operand tag equals `bc_tag` delivers `bc_data` into the new station, so the operand is not lost.
- R7: A station with any non-zero operand tag is never offered for dispatch.
- R8: At most one station is dispatched per cycle. When no offer is being held, the lowest-indexed ready station is offered. `dsp_tag` carries the offered station's tag.
- R9: While `dsp_valid` is 1 and `dsp_ready` is 0, the next cycle keeps `dsp_valid` at 1 with the same `dsp_op`, `dsp_a`, `dsp_b` and `dsp_tag`, even if a lower-indexed station becomes ready.
- R10: A dispatched station is freed by a broadcast carrying its own tag and is free in the cycle after that edge. A broadcast of a station's own tag before it has been dispatched, and a broadcast of tag 0, free nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue stream: an operation is presented |
| iss_ready | output | 1 | Issue stream: a station is free |
| iss_op | input | OP_W | Operation code |
| iss_vj | input | DATA_W | First operand value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | First operand producer tag, 0 if valid |
| iss_vk | input | DATA_W | Second operand value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | Second operand producer tag, 0 if valid |
| iss_tag | output | TAG_W | Tag of the station the next accepted issue fills |
| full | output | 1 | All stations occupied; the issuer must stall |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Tag of the producing station |
| bc_data | input | DATA_W | Result value |
| dsp_valid | output | 1 | Dispatch stream: a ready operation is offered |
| dsp_ready | input | 1 | Dispatch stream: functional unit accepts |
| dsp_op | output | OP_W | Offered operation code |
| dsp_a | output | DATA_W | Offered first operand |
| dsp_b | output | DATA_W | Offered second operand |
| dsp_tag | output | TAG_W | Tag of the offered station |

## Verification
The assertions check these rules on every cycle:
- An offer that is stalled stays frozen.
- At most one station is granted per cycle.
- Occupancy only drops on a cycle that carried a broadcast.
- A full pool with a quiet bus stays full.
- The allocated tag is always inside the pool's range.

Only the bench scenarios can show the following:
- Operand values really come from the right source (issue port, a later broadcast, or the same-cycle forward).
- Wakeup timing is exact for every mix of present, pending and forwarded tags.
- An issue refused while full leaves no trace.
- Priority order holds across a held offer.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Life cycle of one station.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,  // free for allocation
    SLOT_WAIT = 2'd1,  // occupied, waiting for operands or dispatch
    SLOT_SENT = 2'd2   // dispatched, waiting for its own result broadcast
  } slot_state_e;

endpackage

// File: rtl/rs_first_one.sv
module rs_first_one #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  import rs_pkg::*;

  localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

  slot_state_e       state_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] vj_q, vk_q;
  logic [TAG_W-1:0]  qj_q, qk_q;

  // Bus hits against the stored tags and against the tags being issued.
  logic hit_j, hit_k, fwd_j, fwd_k, own_done;
  always_comb begin
    hit_j    = bc_valid_i && (qj_q != '0) && (qj_q == bc_tag_i);
    hit_k    = bc_valid_i && (qk_q != '0) && (qk_q == bc_tag_i);
    fwd_j    = bc_valid_i && (iss_qj_i != '0) && (iss_qj_i == bc_tag_i);
    fwd_k    = bc_valid_i && (iss_qk_i != '0) && (iss_qk_i == bc_tag_i);
    own_done = bc_valid_i && (bc_tag_i == OWN_TAG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      op_q    <= '0;
      vj_q    <= '0;
      vk_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
    end else begin
      unique case (state_q)
        SLOT_IDLE: begin
          if (alloc_i) begin
            state_q <= SLOT_WAIT;
            op_q    <= iss_op_i;
            if (fwd_j) begin
              vj_q <= bc_data_i;
              qj_q <= '0;
            end else begin
              vj_q <= iss_vj_i;
              qj_q <= iss_qj_i;
            end
            if (fwd_k) begin
              vk_q <= bc_data_i;
              qk_q <= '0;
            end else begin
              vk_q <= iss_vk_i;
              qk_q <= iss_qk_i;
            end
          end
        end
        SLOT_WAIT: begin
          if (hit_j) begin
            vj_q <= bc_data_i;
            qj_q <= '0;
          end
          if (hit_k) begin
            vk_q <= bc_data_i;
            qk_q <= '0;
          end
          if (grant_i) state_q <= SLOT_SENT;
        end
        SLOT_SENT: begin
          if (own_done) state_q <= SLOT_IDLE;
        end
        default: state_q <= SLOT_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != SLOT_IDLE);
  assign ready_o = (state_q == SLOT_WAIT) && (qj_q == '0) && (qk_q == '0);
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ready_i,
  input  logic             take_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);

  logic             low_found;
  logic [IDX_W-1:0] low_idx;
  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;

  rs_first_one #(.N(N), .IDX_W(IDX_W)) u_low (
    .req   (ready_i),
    .found (low_found),
    .idx   (low_idx)
  );

  // A stalled offer is pinned until it is taken.
  assign valid_o = hold_q | low_found;
  assign idx_o   = hold_q ? hold_idx_q : low_idx;

  always_comb begin
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_o && take_i && (idx_o == IDX_W'(i))) grant_o[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= valid_o && !take_i;
      hold_idx_q <= idx_o;
    end
  end

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N        = 3,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b,
  output logic [TAG_W-1:0]  dsp_tag
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      busy_vec;
  logic [N-1:0]      ready_vec;
  logic [N-1:0]      grant_vec;
  logic              alloc_found;
  logic [IDX_W-1:0]  alloc_idx;
  logic [IDX_W-1:0]  pick_idx;
  logic [OP_W-1:0]   slot_op [N];
  logic [DATA_W-1:0] slot_vj [N];
  logic [DATA_W-1:0] slot_vk [N];

  // Allocation: lowest free station.
  rs_first_one #(.N(N), .IDX_W(IDX_W)) u_alloc (
    .req   (~busy_vec),
    .found (alloc_found),
    .idx   (alloc_idx)
  );

  assign full      = !alloc_found;
  assign iss_ready = alloc_found;
  assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);

  for (genvar g = 0; g < N; g++) begin : g_slot
    rs_slot #(
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .OP_W   (OP_W),
      .MY_TAG (TAG_BASE + g)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (iss_valid && alloc_found && (alloc_idx == IDX_W'(g))),
      .iss_op_i   (iss_op),
      .iss_vj_i   (iss_vj),
      .iss_qj_i   (iss_qj),
      .iss_vk_i   (iss_vk),
      .iss_qk_i   (iss_qk),
      .bc_valid_i (bc_valid),
      .bc_tag_i   (bc_tag),
      .bc_data_i  (bc_data),
      .grant_i    (grant_vec[g]),
      .busy_o     (busy_vec[g]),
      .ready_o    (ready_vec[g]),
      .op_o       (slot_op[g]),
      .vj_o       (slot_vj[g]),
      .vk_o       (slot_vk[g])
    );
  end

  // Dispatch selection with hold under back-pressure.
  rs_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (ready_vec),
    .take_i  (dsp_ready),
    .valid_o (dsp_valid),
    .idx_o   (pick_idx),
    .grant_o (grant_vec)
  );

  always_comb begin
    dsp_op = '0;
    dsp_a  = '0;
    dsp_b  = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_idx == IDX_W'(i)) begin
        dsp_op = slot_op[i];
        dsp_a  = slot_vj[i];
        dsp_b  = slot_vk[i];
      end
    end
  end

  assign dsp_tag = TAG_W'(TAG_BASE) + TAG_W'(pick_idx);

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N        = 3,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              full,
  input logic              bc_valid,
  input logic              dsp_valid,
  input logic              dsp_ready,
  input logic [OP_W-1:0]   dsp_op,
  input logic [DATA_W-1:0] dsp_a,
  input logic [DATA_W-1:0] dsp_b,
  input logic [TAG_W-1:0]  dsp_tag,
  input logic [N-1:0]      busy_vec,
  input logic [N-1:0]      grant_vec
);

  // R2: allocated tag lies inside this pool's range
  a_r2_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |->
      (int'(iss_tag) >= TAG_BASE) && (int'(iss_tag) < TAG_BASE + N));

  // R3: a full pool with no broadcast cannot gain a free station
  a_r3_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !bc_valid) |=> full);

  // R8: at most one station granted per cycle
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R9: stalled offer stays valid and frozen
  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=>
      (dsp_valid && $stable(dsp_tag) && $stable(dsp_op) &&
       $stable(dsp_a) && $stable(dsp_b)));

  // R10: occupancy drops only after a broadcast
  a_r10_free_on_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(busy_vec) < $past($countones(busy_vec))) |-> $past(bc_valid));

endmodule

bind rs_pool rs_pool_chk #(
  .N        (N),
  .TAG_W    (TAG_W),
  .DATA_W   (DATA_W),
  .OP_W     (OP_W),
  .TAG_BASE (TAG_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_tag   (iss_tag),
  .full      (full),
  .bc_valid  (bc_valid),
  .dsp_valid (dsp_valid),
  .dsp_ready (dsp_ready),
  .dsp_op    (dsp_op),
  .dsp_a     (dsp_a),
  .dsp_b     (dsp_b),
  .dsp_tag   (dsp_tag),
  .busy_vec  (busy_vec),
  .grant_vec (grant_vec)
);

// File: tb/sim_rs_pool.sv
`timescale 1ns/1ps
module sim_rs_pool;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_ready;
  logic [3:0]  iss_op, iss_qj, iss_qk, iss_tag;
  logic [31:0] iss_vj, iss_vk;
  logic        full;
  logic        bc_valid;
  logic [3:0]  bc_tag;
  logic [31:0] bc_data;
  logic        dsp_valid, dsp_ready;
  logic [3:0]  dsp_op, dsp_tag;
  logic [31:0] dsp_a, dsp_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  rs_pool u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
    .iss_tag(iss_tag), .full(full),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
    .dsp_a(dsp_a), .dsp_b(dsp_b), .dsp_tag(dsp_tag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [31:0] vj, logic [3:0] qj,
                       logic [31:0] vk, logic [3:0] qk);
    iss_valid = 1'b1; iss_op = op;
    iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
  endtask

  task automatic bcast(logic [3:0] t, logic [31:0] d);
    bc_valid = 1'b1; bc_tag = t; bc_data = d;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  function automatic logic [31:0] src_val(int q, int base, int k);
    if (q == 0) return 32'(base + k);
    return 32'(q * 1000 + k);
  endfunction

  // One station through its full life: issue, wakeup, dispatch, free.
  task automatic run_one(int qj, int qk, bit fwd, int k);
    bit p9, p10;
    @(negedge clk);
    check("R2 alloc tag", iss_tag, 4'd1);
    issue(4'(k), (qj == 0) ? 32'(10 + k) : 32'hDEAD, 4'(qj),
          (qk == 0) ? 32'(20 + k) : 32'hBEEF, 4'(qk));
    if (fwd) begin
      bc_valid = 1'b1; bc_tag = 4'd9; bc_data = 32'(9000 + k);
    end
    @(negedge clk);
    iss_valid = 1'b0; bc_valid = 1'b0;
    p9  = ((qj == 9) || (qk == 9)) && !fwd;
    p10 = (qj == 10) || (qk == 10);
    check(fwd ? "R6 ready after fwd" : "R4/R7 ready after issue",
          32'(dsp_valid), 32'(!(p9 || p10)));
    if (p9) begin
      bcast(4'd9, 32'(9000 + k));
      check("R5/R7 wake on tag 9", 32'(dsp_valid), 32'(!p10));
    end
    if (p10) begin
      bcast(4'd10, 32'(10000 + k));
      check("R5 wake on tag 10", 32'(dsp_valid), 32'd1);
    end
    check(fwd ? "R6 operand a" : "R5 operand a", dsp_a, src_val(qj, 10, k));
    check(fwd ? "R6 operand b" : "R5 operand b", dsp_b, src_val(qk, 20, k));
    check("R8 dsp_tag", 32'(dsp_tag), 32'd1);
    check("R4 dsp_op", 32'(dsp_op), 32'(k[3:0]));
    dsp_ready = 1'b1;
    @(negedge clk);
    dsp_ready = 1'b0;
    check("R8 single dispatch", 32'(dsp_valid), 32'd0);
    bcast(4'd1, 32'd0);
    check("R10 free after own tag", 32'(full), 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int tv[3];
    tv = '{0, 9, 10};
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_vj = '0; iss_qj = '0;
    iss_vk = '0; iss_qk = '0; bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
    dsp_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 full", 32'(full), 32'd0);
    check("R1 iss_ready", 32'(iss_ready), 32'd1);
    check("R1 dsp_valid", 32'(dsp_valid), 32'd0);
    check("R1 iss_tag", 32'(iss_tag), 32'd1);

    // Sweep every mix of present, pending and forwarded operand tags.
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int f = 0; f < 2; f++)
          run_one(tv[a], tv[b], f[0], a * 6 + b * 2 + f);

    // Fill the pool, all waiting on tag 12.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 fill order", 32'(iss_tag), 32'(i + 1));
      check("R3 not full yet", 32'(full), 32'd0);
      issue(4'(i), 32'h0, 4'd12, 32'(50 + i), 4'd0);
    end
    @(negedge clk);
    iss_valid = 1'b0;
    check("R3 full", 32'(full), 32'd1);
    check("R3 iss_ready low", 32'(iss_ready), 32'd0);
    issue(4'd7, 32'd777, 4'd0, 32'd778, 4'd0);
    @(negedge clk);
    iss_valid = 1'b0;
    check("R3 ignored issue not offered", 32'(dsp_valid), 32'd0);
    bcast(4'd2, 32'd0);
    check("R10 own tag before dispatch", 32'(full), 32'd1);
    bcast(4'd12, 32'd1200);
    check("R5 wake all", 32'(dsp_valid), 32'd1);
    check("R8 lowest first", 32'(dsp_tag), 32'd1);
    @(negedge clk);
    check("R9 held tag", 32'(dsp_tag), 32'd1);
    check("R9 held valid", 32'(dsp_valid), 32'd1);
    dsp_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R8 order", 32'(dsp_tag), 32'(i + 1));
      check("R5 captured a", dsp_a, 32'd1200);
      check("R3 entry intact", dsp_b, 32'(50 + i));
      @(negedge clk);
    end
    dsp_ready = 1'b0;
    check("R3 no extra entry", 32'(dsp_valid), 32'd0);
    bcast(4'd0, 32'd0);
    check("R10 tag 0 frees nothing", 32'(full), 32'd1);
    bcast(4'd2, 32'd0);
    check("R10 freed", 32'(full), 32'd0);
    check("R10 reuse tag 2", 32'(iss_tag), 32'd2);
    bcast(4'd1, 32'd0);
    check("R10 reuse tag 1", 32'(iss_tag), 32'd1);
    bcast(4'd3, 32'd0);

    // Held offer survives a lower station becoming ready.
    @(negedge clk);
    issue(4'd1, 32'd0, 4'd12, 32'd1, 4'd0);
    @(negedge clk);
    check("R2 second slot", 32'(iss_tag), 32'd2);
    issue(4'd2, 32'd2, 4'd0, 32'd3, 4'd0);
    @(negedge clk);
    iss_valid = 1'b0;
    check("R7 pending slot skipped", 32'(dsp_tag), 32'd2);
    bcast(4'd12, 32'd5);
    check("R9 lock on tag 2", 32'(dsp_tag), 32'd2);
    check("R9 lock on a", dsp_a, 32'd2);
    dsp_ready = 1'b1;
    @(negedge clk);
    check("R8 next lowest", 32'(dsp_tag), 32'd1);
    check("R5 late operand", dsp_a, 32'd5);
    @(negedge clk);
    dsp_ready = 1'b0;
    check("R8 drained", 32'(dsp_valid), 32'd0);
    bcast(4'd1, 32'd0);
    bcast(4'd2, 32'd0);
    check("R10 all free", 32'(iss_tag), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule